// File: doc/BRIEF.md
# Fuse-Programmed Product Term Array

This block is the AND plane of a small programmable logic fabric. Every input drives two lines into the plane, its true value and its inverse. Each row of the plane forms one product term. A configuration fuse at each crossing of a row and a line decides whether that line takes part in the row's AND. A configuration store elsewhere on the chip supplies a flat fuse vector and a per-row disable mask. The block captures both into local registers on a load strobe. The term vector is then a purely combinational function of the captured configuration and the live logic inputs, and it feeds a downstream OR plane or output cell.

Fuse polarity is inverted with respect to ordinary enable bits. A cleared fuse means the line is connected. A set fuse means the line is cut off. As a result, a row whose fuses are all set produces a constant high term. A row whose fuses are all cleared ANDs every input with its own inverse, so it produces a constant low term. The disable mask can switch any term off to save power, and a switched-off term reads low.

Top module: `pterm_array`

## Requirements
- R1: While rst_n is low at a rising clock edge, the captured configuration is set to every fuse cut off and every term disabled. From the edge after reset until the first load, term_out is all zeros.
- R2: Fuse bit k of cfg_fuses belongs to row k / (2*N_IN) and column k mod (2*N_IN). A value of 0 connects that column's line into the row's AND, and a value of 1 disconnects it.
- R3: Column 2*i carries logic_in[i] and column 2*i+1 carries its inverse.
- R4: An enabled row whose fuses are all 1 drives its term bit high for every input value.
- R5: A row whose fuses are all 0 drives its term bit low for every input value.
- R6: With fuses in columns 0..3 of 1,0,0,1 and the remaining columns 1, the term equals ~logic_in[0] & logic_in[1]. With 0,1,1,0 in columns 0..3, it equals logic_in[0] & ~logic_in[1].
- R7: When bit r of the captured disable mask is 1, term_out[r] is 0 whatever its fuses and the inputs.
- R8: When cfg_load is high at a rising edge (with rst_n high), cfg_fuses and cfg_disable are captured and govern term_out from just after that edge. When cfg_load is low, changes on those ports have no effect on term_out.
- R9: term_out follows logic_in combinationally, with no clock edge between an input change and the updated term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for fuse vector and disable mask |
| cfg_fuses | input | N_ROWS*2*N_IN | Flat fuse vector, row-major, 0 = connected |
| cfg_disable | input | N_ROWS | Per-term disable mask, 1 = term forced low |
| logic_in | input | N_IN | Logic inputs to the plane |
| term_out | output | N_ROWS | Product-term vector |

## Verification
The bench aims at the two degenerate rows. If the fuse polarity were inverted, an all-cut row would read low and an all-connected row would read high. It also drives single-connection rows. A design that swapped the true and inverse columns, or sliced the fuse vector with the wrong row stride, would then produce the wrong input or the wrong inverse on a named row. Disabled rows whose fuses would otherwise give a high term catch a mask that is ignored or has the wrong polarity. Changing the configuration ports while the strobe is low catches a store that loads freely, and changing inputs between clock edges catches an output that has been registered by mistake.

// File: rtl/pterm_pkg.sv
// Package: shared limits and helpers for the product-term array.
// Assumes: callers pass column counts that fit in 32 bits.
package pterm_pkg;
    // Largest number of rows the disable mask is meant to cover.
    localparam int unsigned MAX_TERMS = 64;

    // Flat fuse index of (row, column) for a plane of ncol columns.
    function automatic int unsigned fuse_index(input int unsigned row,
                                               input int unsigned col,
                                               input int unsigned ncol);
        return row * ncol + col;
    endfunction
endpackage

// File: rtl/pterm_cfg_store.sv
// Module: configuration capture registers for the product-term array.
// Holds the fuse vector and disable mask. Both are loaded on cfg_load.
// On reset every fuse is cut off and every term is disabled.
// Assumes: synchronous active-low reset, single clock domain.
module pterm_cfg_store #(
    parameter int unsigned FUSE_W = 64,
    parameter int unsigned N_ROWS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [FUSE_W-1:0] cfg_fuses,
    input  logic [N_ROWS-1:0] cfg_disable,
    output logic [FUSE_W-1:0] fuse_q,
    output logic [N_ROWS-1:0] dis_q
);
    // Capture or hold the configuration; erase it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q <= '1;
            dis_q  <= '1;
        end else if (cfg_load) begin
            fuse_q <= cfg_fuses;
            dis_q  <= cfg_disable;
        end
    end

    // R1: the cycle after a reset edge shows the erased configuration.
    assert_erased_after_reset_R1: assert property (@(posedge clk)
        disable iff (!rst_n) !$past(rst_n) |-> (&fuse_q && &dis_q));

    // R8: a strobe captures exactly the presented values.
    assert_capture_on_load_R8: assert property (@(posedge clk)
        disable iff (!rst_n) ($past(rst_n) && $past(cfg_load)) |->
        (fuse_q == $past(cfg_fuses) && dis_q == $past(cfg_disable)));

    // R8: without a strobe the configuration holds.
    assert_hold_without_load_R8: assert property (@(posedge clk)
        disable iff (!rst_n) ($past(rst_n) && !$past(cfg_load)) |->
        ($stable(fuse_q) && $stable(dis_q)));
endmodule

// File: rtl/pterm_lines.sv
// Module: input line driver for the AND plane.
// Expands each input into a true line (even column) and an inverse line
// (odd column).
// Assumes: purely combinational, no clock.
module pterm_lines #(
    parameter int unsigned N_IN = 4,
    localparam int unsigned NCOL = 2 * N_IN
) (
    input  logic [N_IN-1:0] logic_in,
    output logic [NCOL-1:0] lines
);
    for (genvar i = 0; i < N_IN; i++) begin : g_pair
        // Drive the true line and the inverse line of input i.
        assign lines[2*i]   = logic_in[i];
        assign lines[2*i+1] = ~logic_in[i];
    end
endmodule

// File: rtl/pterm_row.sv
// Module: one product term of the AND plane.
// A cleared fuse connects its line into the AND. A set fuse removes it.
// A set disable bit forces the term low.
// Assumes: clk and rst_n are used only by the local checks.
module pterm_row #(
    parameter int unsigned NCOL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCOL-1:0] lines,
    input  logic [NCOL-1:0] fuse_row,
    input  logic            dis,
    output logic            term
);
    logic [NCOL-1:0] masked;

    // A removed line reads as 1 so that it drops out of the AND.
    always_comb masked = lines | fuse_row;

    // Reduce the masked lines and apply the disable.
    always_comb term = (&masked) & ~dis;

    // R4: an enabled row with every fuse cut off is constantly high.
    assert_all_cut_high_R4: assert property (@(posedge clk)
        disable iff (!rst_n) (&fuse_row && !dis) |-> term);

    // R5: a row with every fuse connected is constantly low.
    assert_all_connected_low_R5: assert property (@(posedge clk)
        disable iff (!rst_n) (fuse_row == '0) |-> !term);
endmodule

// File: rtl/pterm_array.sv
// Module: fuse-programmed product-term array (top).
// Captures a flat row-major fuse vector and a disable mask on cfg_load.
// Evaluates N_ROWS product terms over the true and inverse lines of
// N_IN inputs.
// Assumes: N_ROWS is between 1 and pterm_pkg::MAX_TERMS, and N_IN >= 1.
module pterm_array #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_ROWS = 8,
    localparam int unsigned NCOL   = 2 * N_IN,
    localparam int unsigned FUSE_W = N_ROWS * NCOL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [FUSE_W-1:0] cfg_fuses,
    input  logic [N_ROWS-1:0] cfg_disable,
    input  logic [N_IN-1:0]   logic_in,
    output logic [N_ROWS-1:0] term_out
);
    logic [FUSE_W-1:0] fuse_q;
    logic [N_ROWS-1:0] dis_q;
    logic [NCOL-1:0]   lines;

    pterm_cfg_store #(.FUSE_W(FUSE_W), .N_ROWS(N_ROWS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_fuses  (cfg_fuses),
        .cfg_disable(cfg_disable),
        .fuse_q     (fuse_q),
        .dis_q      (dis_q)
    );

    pterm_lines #(.N_IN(N_IN)) lines_i (
        .logic_in(logic_in),
        .lines   (lines)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        localparam int unsigned BASE = pterm_pkg::fuse_index(r, 0, NCOL);
        // One AND term per row, fed by its slice of the fuse vector.
        pterm_row #(.NCOL(NCOL)) row_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines   (lines),
            .fuse_row(fuse_q[BASE +: NCOL]),
            .dis     (dis_q[r]),
            .term    (term_out[r])
        );
    end

    // R7: no disabled row ever presents a high term.
    assert_disabled_rows_low_R7: assert property (@(posedge clk)
        disable iff (!rst_n) (term_out & dis_q) == '0);
endmodule

// File: tb/pterm_array_tb.sv
// Bench: a behavioural reference model compared on every falling edge,
// plus directed checks tagged by requirement.
module pterm_array_tb_top;
    localparam int N_IN   = 4;
    localparam int N_ROWS = 8;
    localparam int NCOL   = 2 * N_IN;
    localparam int FUSE_W = N_ROWS * NCOL;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [FUSE_W-1:0] cfg_fuses = '0;
    logic [N_ROWS-1:0] cfg_disable = '0;
    logic [N_IN-1:0]   logic_in = '0;
    logic [N_ROWS-1:0] term_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit started  = 0;
    bit finished = 0;

    logic [FUSE_W-1:0] m_fuse;
    logic [N_ROWS-1:0] m_dis;

    pterm_array #(.N_IN(N_IN), .N_ROWS(N_ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_fuses(cfg_fuses), .cfg_disable(cfg_disable),
        .logic_in(logic_in), .term_out(term_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state: erase on reset, capture on the strobe.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_fuse <= '1;
            m_dis  <= '1;
        end else if (cfg_load) begin
            m_fuse <= cfg_fuses;
            m_dis  <= cfg_disable;
        end
    end

    function automatic logic [N_ROWS-1:0] expect_terms(
            input logic [FUSE_W-1:0] f, input logic [N_ROWS-1:0] d,
            input logic [N_IN-1:0] x);
        logic [N_ROWS-1:0] res;
        for (int r = 0; r < N_ROWS; r++) begin
            bit t = 1;
            for (int c = 0; c < NCOL; c++) begin
                bit line = (c % 2 == 1) ? !x[c/2] : x[c/2];
                if (f[r*NCOL + c] == 1'b0 && !line) t = 0;
            end
            if (d[r]) t = 0;
            res[r] = t;
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [N_ROWS-1:0] got,
                         input logic [N_ROWS-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: term_out=%b expected=%b", tag, got, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (started && !finished)
            check("R2 cycle", term_out, expect_terms(m_fuse, m_dis, logic_in));
    end

    task automatic load(input logic [FUSE_W-1:0] f, input logic [N_ROWS-1:0] d);
        @(posedge clk); #1;
        cfg_fuses = f; cfg_disable = d; cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    function automatic logic [FUSE_W-1:0] set_row(input logic [FUSE_W-1:0] f,
            input int r, input logic [NCOL-1:0] v);
        f[r*NCOL +: NCOL] = v;
        return f;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: term_out=%b expected=done", term_out);
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [FUSE_W-1:0] f;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: erased configuration gives all terms low.
        @(negedge clk);
        logic_in = 4'b1010; #1;
        check("R1 reset", term_out, '0);

        // R4: every row cut off and enabled -> all high.
        load('1, '0);
        for (int v = 0; v < 16; v += 5) begin
            logic_in = v[N_IN-1:0]; #1;
            check("R4 all cut", term_out, '1);
        end

        // R5: row 0 fully connected stays low.
        load(set_row('1, 0, '0), '0);
        for (int v = 0; v < 16; v += 3) begin
            logic_in = v[N_IN-1:0]; #1;
            check("R5 all connected", term_out, 8'hFE);
        end

        // R6: fuse patterns 1001 and 0110 on columns 0..3 (bit k = column k).
        f = set_row('1, 1, 8'b1111_1001);
        f = set_row(f, 2, 8'b1111_0110);
        load(f, '0);
        for (int v = 0; v < 4; v++) begin
            logic [N_ROWS-1:0] e = '1;
            logic_in = {2'b01, v[1:0]}; #1;
            e[1] = !logic_in[0] && logic_in[1];
            e[2] = logic_in[0] && !logic_in[1];
            check("R6 two-input terms", term_out, e);
        end

        // R3: single connections pick true or inverse lines; stride per row.
        f = set_row('1, 3, 8'b1101_1111);   // column 5: ~in2
        f = set_row(f, 4, 8'b1011_1111);    // column 6: in3
        f = set_row(f, 7, 8'b1111_1101);    // column 1: ~in0
        load(f, '0);
        for (int v = 0; v < 16; v++) begin
            logic [N_ROWS-1:0] e = '1;
            logic_in = v[N_IN-1:0]; #1;
            e[3] = !logic_in[2];
            e[4] = logic_in[3];
            e[7] = !logic_in[0];
            check("R3 line order", term_out, e);
        end

        // R7: disable mask forces terms low even when fuses give high.
        load('1, 8'b1000_0101);
        logic_in = 4'b0110; #1;
        check("R7 disabled", term_out, 8'b0111_1010);

        // R8: config ports move without strobe -> no effect.
        @(posedge clk); #1;
        cfg_fuses = '0; cfg_disable = '1;
        repeat (3) @(posedge clk);
        #2 check("R8 no load", term_out, 8'b0111_1010);
        load(set_row('1, 5, '0), 8'b0000_0001);
        #1 check("R8 load", term_out, 8'b1101_1110);

        // R9: inputs change between edges with immediate effect.
        load(set_row('1, 6, 8'b1111_1110), '0);   // column 0: in0
        logic_in = 4'b0000; #1;
        check("R9 input low", term_out, 8'b1011_1111);
        logic_in = 4'b0001; #1;
        check("R9 input high", term_out, 8'hFF);

        // Random sweep checked by the per-cycle model compare.
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); #2;
            cfg_fuses   = {$urandom, $urandom} | {$urandom, $urandom};
            cfg_disable = 8'($urandom) & 8'($urandom);
            cfg_load    = ($urandom % 4) == 0;
            logic_in    = 4'($urandom);
        end
        @(posedge clk); #2 cfg_load = 1'b0;
        @(negedge clk); @(negedge clk);
        #1 finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end
endmodule